// File: doc/BRIEF.md
# Count/Compare Timer Interrupt Unit

This block pairs a free-running 32-bit cycle counter with a 32-bit compare register and raises a timer interrupt when the counter steps onto the compare value. The interrupt is sticky. The only way to drop it is to write the compare register, and any such write counts, including a write that stores the same value again. Software arms a one-shot event by reading the counter, adding a delta and writing the sum to compare. Because the arithmetic wraps modulo 2^32, any delta up to 0x7FFFFFFF fires once after that many ticks.

A small register port gives access to the counter, the compare register and a read-only status word. The status word shows the interrupt in two places: a fixed timer bit and one of the eight hardware pending-line positions, chosen by a parameter. An optional chain of latch stages delays the interrupt by a set number of counter ticks. This models routing through logic outside the core. A parameter selects whether the counter advances on every enabled clock or on every second enabled clock.

Top module: `cct_timer`

## Requirements
- R1: While reset is high and on the first cycle after it, the counter reads 0, the compare register reads 0, the status word reads 0 and `timer_irq` is low.
- R2: With `count_en` high and TICK_DIV=1, the counter, read at address 0, grows by exactly 1 on every clock.
- R3: The counter wraps from 0xFFFFFFFF to 0x00000000. A compare value reached across the wrap still fires after exactly delta ticks.
- R4: With LATENCY=0, the interrupt rises on the same clock edge at which an increment makes the counter equal to the compare register (address 1).
- R5: Once pending, the interrupt stays high while the counter moves on, for as long as the compare register is not written.
- R6: Any write to the compare register clears the pending interrupt on that edge, even when the written value equals the current compare value.
- R7: If a compare write and a counter step onto the old compare value happen on the same edge, the write wins and nothing is pending. The new compare value is tested from the next step onward.
- R8: The status word (address 2) has bit 30 and bit LINE_BIT (8 to 15, default 15) equal to `timer_irq`, and all other bits are 0. Writes to address 2 have no effect.
- R9: With LATENCY=N>0, `timer_irq` rises exactly N counter ticks after the matching step.
- R10: With `count_en` low, the counter holds its value and no new match is raised.
- R11: A write to address 0 loads the counter with the written value on that edge.
- R12: With TICK_DIV=2, the counter advances by exactly 1 per two enabled clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| count_en | input | 1 | Counter enable |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 counter, 1 compare, 2 status |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| timer_irq | output | 1 | Timer interrupt, after the optional latch stages |

## Verification
A short delta without wrap is sampled one tick before and on the match edge, which separates an early, late or missing match. A delta that crosses 0xFFFFFFFF shows whether the comparison uses modulo arithmetic. Acknowledges that rewrite the unchanged compare value, and compare writes that land on the exact match edge with an old or a new target, separate write-triggered clearing from value-change clearing and test the write-wins ordering. A second instance with three latch stages, the halved tick and line 10 measures the rise lag in clocks, the step rate and the mirror position.

// File: rtl/cct_pkg.sv
package cct_pkg;

    localparam int WORD_W         = 32;
    localparam int TIMER_FLAG_BIT = 30;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {
        SEL_COUNT   = 2'd0,
        SEL_COMPARE = 2'd1,
        SEL_STATUS  = 2'd2,
        SEL_NONE    = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic  load_count;
        logic  load_compare;
        word_t value;
    } reg_write_t;

    function automatic word_t build_status(input logic irq, input int line_bit);
        word_t s;
        s = '0;
        s[TIMER_FLAG_BIT] = irq;
        s[line_bit]       = irq;
        return s;
    endfunction

endpackage

// File: rtl/cct_tick_gen.sv
module cct_tick_gen #(
    parameter int TICK_DIV = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic count_en,
    output logic tick
);
    generate
        if (TICK_DIV == 1) begin : g_every
            logic unused_bits;
            assign unused_bits = ^{clk, rst};
            assign tick = count_en;
        end else begin : g_half
            logic phase;
            always_ff @(posedge clk) begin
                if (rst)           phase <= 1'b0;
                else if (count_en) phase <= ~phase;
            end
            assign tick = count_en & phase;

            a_r12_alternate: assert property (@(posedge clk) disable iff (rst)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/cct_counter.sv
module cct_counter
    import cct_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] count,
    output logic [W-1:0] count_next,
    output logic         step
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    assign step       = tick & ~load;
    assign count_next = count + ONE;

    always_ff @(posedge clk) begin
        if (rst)       count <= '0;
        else if (load) count <= load_val;
        else if (tick) count <= count_next;
    end

    a_r2_count_step: assert property (@(posedge clk) disable iff (rst)
        (tick && !load) |=> count == $past(count) + ONE);
    a_r3_wrap: assert property (@(posedge clk) disable iff (rst)
        (tick && !load && count == '1) |=> count == '0);
    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        (!tick && !load) |=> $stable(count));
    a_r11_load: assert property (@(posedge clk) disable iff (rst)
        load |=> count == $past(load_val));
endmodule

// File: rtl/cct_match.sv
module cct_match
    import cct_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step,
    input  logic [W-1:0] count,
    input  logic [W-1:0] count_next,
    input  logic         cmp_wr,
    input  logic [W-1:0] cmp_wdata,
    output logic [W-1:0] cmp,
    output logic         pend
);
    logic hit;
    assign hit = step & (count_next == cmp);

    always_ff @(posedge clk) begin
        if (rst)         cmp <= '0;
        else if (cmp_wr) cmp <= cmp_wdata;
    end

    // compare write has priority over a same-edge hit
    always_ff @(posedge clk) begin
        if (rst)         pend <= 1'b0;
        else if (cmp_wr) pend <= 1'b0;
        else if (hit)    pend <= 1'b1;
    end

    a_r4_rise_on_match: assert property (@(posedge clk) disable iff (rst)
        $rose(pend) |-> (count == cmp && !$past(cmp_wr)));
    a_r5_sticky: assert property (@(posedge clk) disable iff (rst)
        (pend && !cmp_wr) |=> pend);
    a_r6_ack: assert property (@(posedge clk) disable iff (rst)
        cmp_wr |=> (!pend && cmp == $past(cmp_wdata)));
    a_r10_no_step_no_rise: assert property (@(posedge clk) disable iff (rst)
        (!step && !pend) |=> !pend);
endmodule

// File: rtl/cct_irq_delay.sv
module cct_irq_delay #(
    parameter int LATENCY = 0
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic clr,
    input  logic pend_in,
    output logic irq_out
);
    generate
        if (LATENCY == 0) begin : g_direct
            logic unused_bits;
            assign unused_bits = ^{clk, rst, tick, clr};
            assign irq_out = pend_in;
        end else begin : g_chain
            logic [LATENCY-1:0] stg;
            for (genvar i = 0; i < LATENCY; i++) begin : g_stage
                logic src;
                if (i == 0) begin : g_head
                    assign src = pend_in;
                end else begin : g_body
                    assign src = stg[i-1];
                end
                always_ff @(posedge clk) begin
                    if (rst || clr) stg[i] <= 1'b0;
                    else if (tick)  stg[i] <= src;
                end
            end
            assign irq_out = stg[LATENCY-1];

            a_r9_never_ahead: assert property (@(posedge clk) disable iff (rst)
                irq_out |-> pend_in);
            a_r9_clear: assert property (@(posedge clk) disable iff (rst)
                clr |=> !irq_out);
        end
    endgenerate
endmodule

// File: rtl/cct_timer.sv
module cct_timer
    import cct_pkg::*;
#(
    parameter int LATENCY  = 0,
    parameter int TICK_DIV = 1,
    parameter int LINE_BIT = 15
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        count_en,
    input  logic        reg_wr,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        timer_irq
);
    localparam int W = WORD_W;

    reg_sel_e   sel;
    reg_write_t wreq;
    logic       tick, step, pend;
    word_t      count, count_next, cmp, status;

    assign sel               = reg_sel_e'(reg_addr);
    assign wreq.load_count   = reg_wr && (sel == SEL_COUNT);
    assign wreq.load_compare = reg_wr && (sel == SEL_COMPARE);
    assign wreq.value        = reg_wdata;

    cct_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk(clk), .rst(rst), .count_en(count_en), .tick(tick)
    );

    cct_counter #(.W(W)) u_count (
        .clk(clk), .rst(rst), .tick(tick),
        .load(wreq.load_count), .load_val(wreq.value),
        .count(count), .count_next(count_next), .step(step)
    );

    cct_match #(.W(W)) u_match (
        .clk(clk), .rst(rst), .step(step),
        .count(count), .count_next(count_next),
        .cmp_wr(wreq.load_compare), .cmp_wdata(wreq.value),
        .cmp(cmp), .pend(pend)
    );

    cct_irq_delay #(.LATENCY(LATENCY)) u_delay (
        .clk(clk), .rst(rst), .tick(tick),
        .clr(wreq.load_compare), .pend_in(pend), .irq_out(timer_irq)
    );

    assign status = build_status(timer_irq, LINE_BIT);

    always_comb begin
        unique case (sel)
            SEL_COUNT:   reg_rdata = count;
            SEL_COMPARE: reg_rdata = cmp;
            SEL_STATUS:  reg_rdata = status;
            default:     reg_rdata = '0;
        endcase
    end

    a_r8_mirror: assert property (@(posedge clk) disable iff (rst)
        (sel == SEL_STATUS) |-> (reg_rdata[TIMER_FLAG_BIT] == timer_irq
                                 && reg_rdata[LINE_BIT] == timer_irq));
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        $fell(rst) |-> (!timer_irq && count == '0 && cmp == '0));
endmodule

// File: tb/cct_timer_tb.sv
module cct_timer_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic        en_a = 0, wr_a = 0, irq_a;
    logic [1:0]  ad_a = 0;
    logic [31:0] wd_a = 0, rd_a;
    logic        en_b = 0, wr_b = 0, irq_b;
    logic [1:0]  ad_b = 0;
    logic [31:0] wd_b = 0, rd_b;

    int total = 0;
    int bad   = 0;

    cct_timer u_dut (
        .clk(clk), .rst(rst), .count_en(en_a), .reg_wr(wr_a), .reg_addr(ad_a),
        .reg_wdata(wd_a), .reg_rdata(rd_a), .timer_irq(irq_a)
    );

    cct_timer #(.LATENCY(3), .TICK_DIV(2), .LINE_BIT(10)) u_dut_slow (
        .clk(clk), .rst(rst), .count_en(en_b), .reg_wr(wr_b), .reg_addr(ad_b),
        .reg_wdata(wd_b), .reg_rdata(rd_b), .timer_irq(irq_b)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input int d, input logic [1:0] a, input logic [31:0] v);
        if (d == 0) begin wr_a = 1; ad_a = a; wd_a = v; end
        else        begin wr_b = 1; ad_b = a; wd_b = v; end
        @(negedge clk);
        wr_a = 0; wr_b = 0;
    endtask

    task automatic rd(input int d, input logic [1:0] a, output logic [31:0] v);
        if (d == 0) ad_a = a; else ad_b = a;
        #1;
        v = (d == 0) ? rd_a : rd_b;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        step(2);
        rd(0, 0, v); chk("R1 count", v, 0);
        rd(0, 1, v); chk("R1 compare", v, 0);
        rd(0, 2, v); chk("R1 status", v, 0);
        chk("R1 irq", {31'b0, irq_a}, 0);
        rd(1, 2, v); chk("R1 status slow", v, 0);
        rst = 0;
        step(1);
        rd(0, 0, v); chk("R1 count after release", v, 0);
    endtask

    task automatic t_count();
        logic [31:0] c, v;
        en_a = 1;
        rd(0, 0, c);
        step(1); rd(0, 0, v); chk("R2 +1", v, c + 1);
        step(5); rd(0, 0, v); chk("R2 +6", v, c + 6);
        en_a = 0;
        rd(0, 0, c);
        step(4); rd(0, 0, v); chk("R10 hold", v, c);
    endtask

    task automatic t_load_wrap();
        logic [31:0] v;
        wr(0, 0, 32'h0000_1234);
        rd(0, 0, v); chk("R11 load", v, 32'h0000_1234);
        wr(0, 0, 32'hFFFF_FFFE);
        en_a = 1;
        step(1); rd(0, 0, v); chk("R3 top", v, 32'hFFFF_FFFF);
        step(1); rd(0, 0, v); chk("R3 wrap", v, 32'h0);
        en_a = 0;
    endtask

    task automatic t_match();
        logic [31:0] v;
        wr(0, 0, 100);
        wr(0, 1, 105);
        en_a = 1;
        step(4); chk("R4 before match", {31'b0, irq_a}, 0);
        rd(0, 2, v); chk("R8 status idle", v, 0);
        step(1); chk("R4 on match", {31'b0, irq_a}, 1);
        rd(0, 0, v); chk("R4 count at match", v, 105);
        rd(0, 2, v); chk("R8 status set", v, 32'h4000_8000);
        step(10); chk("R5 sticky", {31'b0, irq_a}, 1);
        en_a = 0;
        wr(0, 2, 32'h0);
        rd(0, 2, v); chk("R8 status write ignored", v, 32'h4000_8000);
        rd(0, 1, v);
        wr(0, 1, v);
        chk("R6 ack same value", {31'b0, irq_a}, 0);
        rd(0, 1, v); chk("R6 compare kept", v, 105);
        en_a = 1; step(5); en_a = 0;
        chk("R6 stays clear", {31'b0, irq_a}, 0);
    endtask

    task automatic t_collision();
        logic [31:0] v;
        wr(0, 0, 300);
        wr(0, 1, 301);
        en_a = 1; wr_a = 1; ad_a = 1; wd_a = 500;
        @(negedge clk);
        wr_a = 0; en_a = 0;
        chk("R7 write wins", {31'b0, irq_a}, 0);
        rd(0, 0, v); chk("R7 count stepped", v, 301);
        wr(0, 0, 300);
        wr(0, 1, 301);
        en_a = 1; wr_a = 1; ad_a = 1; wd_a = 302;
        @(negedge clk);
        wr_a = 0;
        chk("R7 no hit on write edge", {31'b0, irq_a}, 0);
        step(1);
        chk("R7 new target fires", {31'b0, irq_a}, 1);
        en_a = 0;
        wr(0, 1, 0);
    endtask

    task automatic t_wrap_delta();
        logic [31:0] v;
        wr(0, 0, 32'hFFFF_FFF0);
        wr(0, 1, 32'h0000_0005);
        en_a = 1;
        step(20); chk("R3 before wrapped match", {31'b0, irq_a}, 0);
        step(1);  chk("R3 wrapped match", {31'b0, irq_a}, 1);
        rd(0, 0, v); chk("R3 count", v, 5);
        en_a = 0;
    endtask

    task automatic t_slow();
        logic [31:0] v, c;
        int seen_cnt, seen_irq;
        wr(1, 0, 0);
        en_b = 1;
        rd(1, 0, c);
        step(2); rd(1, 0, v); chk("R12 half rate 2", v, c + 1);
        step(4); rd(1, 0, v); chk("R12 half rate 6", v, c + 3);
        en_b = 0;
        wr(1, 0, 50);
        wr(1, 1, 52);
        en_b = 1;
        seen_cnt = -1; seen_irq = -1;
        for (int i = 0; i < 40; i++) begin
            step(1);
            rd(1, 0, v);
            if (seen_cnt < 0 && v == 52) seen_cnt = i;
            if (seen_irq < 0 && irq_b) seen_irq = i;
        end
        en_b = 0;
        chk("R9 lag in clocks", seen_irq - seen_cnt, 6);
        rd(1, 2, v); chk("R8 line position", v, 32'h4000_0400);
        wr(1, 1, 52);
        chk("R6 slow ack", {31'b0, irq_b}, 0);
    endtask

    initial begin
        t_reset();
        t_count();
        t_load_wrap();
        t_match();
        t_collision();
        t_wrap_delta();
        t_slow();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule